// File: doc/BRIEF.md
# Slot-Masked Serial Audio Transmit Lane

This block drives one serial audio data pin. A clock generator outside the block supplies two single-cycle strobes in the system clock domain. `bit_tick` marks each bit-clock period and `frame_tick` marks the bit clock on which a frame begins. On every bit tick the lane works out which slot of the frame and which bit of that slot is due. When a slot begins and its bit in the slot mask is set, the lane pulls one 32-bit word from a valid/ready source. It then shifts the word out MSB first, placed inside the slot according to the chosen framing standard.

The framing settings are sampled into a shadow copy only while `port_en` is low, so they stay fixed for the whole time the lane runs. These settings are the standard, the sample width, the slot width, the TDM switch and the slot count. Slots whose mask bit is clear carry zeros. If a slot that is enabled finds no word waiting, the lane raises `underflow` for one cycle, sends zeros in that slot and keeps counting slots, so the frame alignment is unchanged.

Top module: `tdm_slot_tx`

## Requirements
- R1: While `port_en` is low, `sdata`, `underflow` and `fifo_ready` are 0. After `port_en` rises, nothing is fetched and `sdata` stays 0 until the first `frame_tick` arrives with a `bit_tick`.
- R2: A slot is 16 bit ticks long when `cfg_dsize`=00 and `cfg_slot32`=0, and 32 bit ticks long otherwise. A frame holds `cfg_slots` slots when `cfg_tdm`=1 (even values 2 to 16; odd values round down, and values out of range are clamped) and 2 slots when `cfg_tdm`=0.
- R3: The sample width is 16 bits for `cfg_dsize`=00, 24 bits for 01, and 32 bits for 10 or 11. The sample sits right-aligned in `fifo_data`, so a sample of D bits occupies bits D-1:0. Bits above D are ignored. Samples go out MSB first.
- R4: With `cfg_std`=00 (I2S) or 11 (PCM), the MSB of slot 0 goes out on the bit tick after the `frame_tick`. The bit sent on the `frame_tick` itself is the final bit of the previous frame's last slot, or 0 on the first frame after enabling.
- R5: With `cfg_std`=01 (left-aligned), the MSB goes out on the first bit tick of its slot. Bits past the sample width are 0.
- R6: With `cfg_std`=10 (right-aligned), the LSB goes out on the last bit tick of its slot. Bits before the sample are 0.
- R7: `fifo_ready` rises for exactly one cycle, together with `bit_tick`, at the start of each slot k whose mask bit `slot_mask[k]` is 1. Slots whose mask bit is 0 fetch nothing and send zeros.
- R8: When `fifo_ready` is high and `fifo_valid` is low, `underflow` is 1 in the following cycle. That slot sends zeros, and later slots keep their positions and fetch as usual.
- R9: The framing settings are captured only while `port_en` is low. Changing them while `port_en` is high has no effect on the output.
- R10: `sdata` changes only in the cycle after a `bit_tick` is sampled, and holds its value between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Lane enable; framing settings load while low |
| cfg_std | input | 2 | Framing standard: 00 I2S, 01 left-aligned, 10 right-aligned, 11 PCM |
| cfg_dsize | input | 2 | Sample width: 00 16-bit, 01 24-bit, 10 32-bit |
| cfg_slot32 | input | 1 | 32-bit slots when sample width is 16-bit |
| cfg_tdm | input | 1 | Use `cfg_slots` slots per frame instead of 2 |
| cfg_slots | input | 5 | Slots per frame in TDM mode |
| slot_mask | input | MAX_SLOTS | Per-slot enable, bit k for slot k |
| fifo_data | input | WORD_W | Word offered by the source |
| fifo_valid | input | 1 | Source has a word |
| fifo_ready | output | 1 | Word taken this cycle when valid |
| bit_tick | input | 1 | One pulse per bit clock |
| frame_tick | input | 1 | Frame start, coincident with a bit_tick |
| sdata | output | 1 | Serial data out |
| underflow | output | 1 | One-cycle pulse when an enabled slot found no word |

## Verification
The bench builds the lane with its default parameters: 16 mask bits and 32-bit words. This lets it run an 8-slot PCM frame with a sparse mask and a 4-slot right-aligned frame, next to the two-slot I2S, left-aligned and right-aligned cases. Every sample width, both slot widths and all four standards appear. The FIFO words carry noise in their upper bits, so placement errors and leaks of unused bits show up directly on the pin.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
package tdm_tx_pkg;

  typedef enum logic [1:0] {
    STD_I2S   = 2'b00,
    STD_LEFT  = 2'b01,
    STD_RIGHT = 2'b10,
    STD_PCM   = 2'b11
  } std_e;

  typedef struct packed {
    std_e       std;
    logic [1:0] dsize;
    logic       slot32;
    logic       tdm;
    logic [4:0] slots;
  } frame_cfg_t;

  // Sample width in bits for a size code.
  function automatic logic [5:0] f_data_bits(input logic [1:0] dsize);
    case (dsize)
      2'b00:   return 6'd16;
      2'b01:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // Slot width: only a 16-bit sample may use a 16-bit slot.
  function automatic logic [5:0] f_slot_len(input logic [1:0] dsize, input logic slot32);
    return (dsize == 2'b00 && !slot32) ? 6'd16 : 6'd32;
  endfunction

  // Slots per frame, even, clamped to 2..cap.
  function automatic logic [4:0] f_slot_count(input logic tdm, input logic [4:0] req,
                                              input logic [4:0] cap);
    logic [4:0] n;
    n = {req[4:1], 1'b0};
    if (!tdm || n < 5'd2) return 5'd2;
    if (n > cap) return cap;
    return n;
  endfunction

  // Bit of a word due at a slot position, MSB first.
  function automatic logic f_bit_pick(input logic [31:0] w, input std_e std,
                                      input logic [5:0] dbits, input logic [5:0] slen,
                                      input logic [5:0] pos);
    logic [5:0] lead;
    logic [5:0] rel;
    logic [5:0] idx;
    lead = (std == STD_RIGHT) ? (slen - dbits) : 6'd0;
    rel  = pos - lead;
    idx  = dbits - 6'd1 - rel;
    if (pos < lead || rel >= dbits) return 1'b0;
    return w[idx[4:0]];
  endfunction

endpackage

// File: rtl/tdm_tx_cfg_shadow.sv
`timescale 1ns/1ps
module tdm_tx_cfg_shadow
  import tdm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_en,
  input  frame_cfg_t cfg_in,
  output frame_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{std: STD_I2S, dsize: 2'b00, slot32: 1'b0, tdm: 1'b0, slots: 5'd2};
    end else if (!port_en) begin
      cfg_q <= cfg_in;
    end
  end

  // R9: settings frozen while the lane runs
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && $past(port_en)) |-> $stable(cfg_q));

endmodule

// File: rtl/tdm_tx_slot_seq.sv
`timescale 1ns/1ps
module tdm_tx_slot_seq #(
  parameter int unsigned MAX_SLOTS = 16,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS),
  localparam int unsigned POS_W    = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              bit_tick,
  input  logic              frame_tick,
  input  logic              delayed,
  input  logic [POS_W-1:0]  slen,
  input  logic [SLOT_W:0]   nslots,
  output logic              step,
  output logic              slot_start,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [POS_W-1:0]  cur_pos
);

  logic [SLOT_W-1:0] slot_q, slot_n, last_slot;
  logic [POS_W-1:0]  pos_q, pos_n;
  logic              run_q;

  assign last_slot = SLOT_W'(nslots - 1'b1);

  always_comb begin
    slot_n = slot_q;
    pos_n  = pos_q;
    if (frame_tick) begin
      if (delayed) begin
        slot_n = last_slot;
        pos_n  = slen - 1'b1;
      end else begin
        slot_n = '0;
        pos_n  = '0;
      end
    end else if (pos_q == slen - 1'b1) begin
      pos_n  = '0;
      slot_n = (slot_q == last_slot) ? '0 : slot_q + 1'b1;
    end else begin
      pos_n = pos_q + 1'b1;
    end
  end

  assign step       = port_en && bit_tick && (run_q || frame_tick);
  assign slot_start = step && (pos_n == '0);
  assign cur_slot   = slot_n;
  assign cur_pos    = pos_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      pos_q  <= '0;
    end else if (!port_en) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      pos_q  <= '0;
    end else if (step) begin
      run_q  <= 1'b1;
      slot_q <= slot_n;
      pos_q  <= pos_n;
    end
  end

  // R2: position stays inside the slot, slot inside the frame
  a_r2_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pos_q < slen));
  a_r2_slot_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ({1'b0, slot_q} < nslots));

endmodule

// File: rtl/tdm_tx_bit_fmt.sv
`timescale 1ns/1ps
module tdm_tx_bit_fmt
  import tdm_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned POS_W = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              step,
  input  logic              slot_start,
  input  logic              slot_on,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_valid,
  input  std_e              std,
  input  logic [POS_W-1:0]  dbits,
  input  logic [POS_W-1:0]  slen,
  input  logic [POS_W-1:0]  pos,
  output logic              fifo_ready,
  output logic              sdata,
  output logic              underflow
);

  logic [WORD_W-1:0] word_q, word_n;
  logic              fetch;

  assign fetch      = slot_start && slot_on;
  assign fifo_ready = fetch;

  always_comb begin
    word_n = word_q;
    if (slot_start) word_n = (fetch && fifo_valid) ? fifo_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      sdata     <= 1'b0;
      underflow <= 1'b0;
    end else if (!port_en) begin
      word_q    <= '0;
      sdata     <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= fetch && !fifo_valid;
      if (step) begin
        word_q <= word_n;
        sdata  <= f_bit_pick(word_n, std, dbits, slen, pos);
      end
    end
  end

  // R8: an underflow pulse always follows an unserved request
  a_r8_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(fifo_ready && !fifo_valid));
  // R1: quiet outputs when disabled
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!sdata && !underflow));
  // R10: no change between bit ticks
  a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !step) |=> $stable(sdata));

endmodule

// File: rtl/tdm_slot_tx.sv
`timescale 1ns/1ps
module tdm_slot_tx
  import tdm_tx_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 16,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS),
  localparam int unsigned POS_W    = $clog2(WORD_W) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 port_en,
  input  logic [1:0]           cfg_std,
  input  logic [1:0]           cfg_dsize,
  input  logic                 cfg_slot32,
  input  logic                 cfg_tdm,
  input  logic [4:0]           cfg_slots,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  input  logic [WORD_W-1:0]    fifo_data,
  input  logic                 fifo_valid,
  output logic                 fifo_ready,
  input  logic                 bit_tick,
  input  logic                 frame_tick,
  output logic                 sdata,
  output logic                 underflow
);

  frame_cfg_t        cfg_in, cfg_q;
  logic [POS_W-1:0]  dbits, slen, cur_pos;
  logic [SLOT_W:0]   nslots;
  logic [SLOT_W-1:0] cur_slot;
  logic              delayed, step, slot_start, slot_on;

  assign cfg_in = '{std: std_e'(cfg_std), dsize: cfg_dsize, slot32: cfg_slot32,
                    tdm: cfg_tdm, slots: cfg_slots};

  tdm_tx_cfg_shadow u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_en (port_en),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q)
  );

  assign dbits   = POS_W'(f_data_bits(cfg_q.dsize));
  assign slen    = POS_W'(f_slot_len(cfg_q.dsize, cfg_q.slot32));
  assign nslots  = (SLOT_W+1)'(f_slot_count(cfg_q.tdm, cfg_q.slots, 5'(MAX_SLOTS)));
  assign delayed = (cfg_q.std == STD_I2S) || (cfg_q.std == STD_PCM);

  tdm_tx_slot_seq #(.MAX_SLOTS(MAX_SLOTS), .WORD_W(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .bit_tick   (bit_tick),
    .frame_tick (frame_tick),
    .delayed    (delayed),
    .slen       (slen),
    .nslots     (nslots),
    .step       (step),
    .slot_start (slot_start),
    .cur_slot   (cur_slot),
    .cur_pos    (cur_pos)
  );

  assign slot_on = slot_mask[cur_slot];

  tdm_tx_bit_fmt #(.WORD_W(WORD_W)) u_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .step       (step),
    .slot_start (slot_start),
    .slot_on    (slot_on),
    .fifo_data  (fifo_data),
    .fifo_valid (fifo_valid),
    .std        (cfg_q.std),
    .dbits      (dbits),
    .slen       (slen),
    .pos        (cur_pos),
    .fifo_ready (fifo_ready),
    .sdata      (sdata),
    .underflow  (underflow)
  );

  // R7: a fetch only on an enabled slot's bit tick while running
  a_r7_fetch_on_enabled_tick: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (bit_tick && port_en && slot_mask[cur_slot]));

endmodule

// File: tb/tdm_slot_tx_tb.sv
`timescale 1ns/1ps
module tdm_slot_tx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic [1:0]  cfg_std = 2'b00;
  logic [1:0]  cfg_dsize = 2'b00;
  logic        cfg_slot32 = 1'b0;
  logic        cfg_tdm = 1'b0;
  logic [4:0]  cfg_slots = 5'd2;
  logic [15:0] slot_mask = 16'h0;
  logic [31:0] fifo_data;
  logic        fifo_valid;
  logic        fifo_ready;
  logic        bit_tick = 1'b0;
  logic        frame_tick = 1'b0;
  logic        sdata;
  logic        underflow;

  logic [31:0] fw [0:63];
  int          fptr = 0;
  int          fcount = 0;
  logic        exp_s [0:2047];
  int          n_vec = 0;
  int          n_bad = 0;

  assign fifo_valid = (fptr < fcount);
  assign fifo_data  = fw[fptr[5:0]];

  always #2 clk = ~clk;

  tdm_slot_tx u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_std(cfg_std),
    .cfg_dsize(cfg_dsize), .cfg_slot32(cfg_slot32), .cfg_tdm(cfg_tdm),
    .cfg_slots(cfg_slots), .slot_mask(slot_mask), .fifo_data(fifo_data),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .bit_tick(bit_tick),
    .frame_tick(frame_tick), .sdata(sdata), .underflow(underflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One bit clock: tick, let outputs register, then one idle cycle.
  task automatic bit_step(input bit fs, output bit rdy, output bit sd, output bit ud);
    bit took;
    @(negedge clk);
    bit_tick = 1'b1;
    frame_tick = fs;
    #1;
    rdy  = fifo_ready;
    took = fifo_ready && fifo_valid;
    @(posedge clk);
    #1;
    bit_tick = 1'b0;
    frame_tick = 1'b0;
    if (took) fptr++;
    sd = sdata;
    ud = underflow;
    @(negedge clk);
    #1;
    check(sdata == sd, "R10", "sdata held between ticks", sdata, sd);
  endtask

  task automatic t_quiet();
    bit r, s, u;
    check(sdata == 1'b0 && underflow == 1'b0 && fifo_ready == 1'b0, "R1",
          "outputs after reset", {sdata, underflow, fifo_ready}, 0);
    slot_mask = 16'hFFFF;
    fw[0] = 32'hFFFF_FFFF;
    fptr = 0;
    fcount = 1;
    bit_step(1'b1, r, s, u);
    check(!r && !s && !u, "R1", "disabled lane ignores ticks", {r, s, u}, 0);
    port_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      bit_step(1'b0, r, s, u);
      check(!r && !s, "R1", "no activity before frame start", {r, s}, 0);
    end
    port_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_case(input string tag, input logic [1:0] std, input logic [1:0] dsz,
                          input bit s32, input bit tdm, input logic [4:0] slots,
                          input logic [15:0] mask, input int frames, input int words,
                          input bit disturb, input int seed);
    int  d, l, n, used, exp_ud, exp_rdy, got_ud, got_rdy, lead, total;
    bit  dly, r, s, u, e;
    logic [31:0] w;
    port_en = 1'b0;
    cfg_std = std; cfg_dsize = dsz; cfg_slot32 = s32; cfg_tdm = tdm; cfg_slots = slots;
    slot_mask = mask;
    for (int i = 0; i < 64; i++) fw[i] = (32'h9E37_79B9 * (i + seed)) ^ 32'h5A5A_0F0F;
    fptr = 0;
    fcount = words;
    repeat (2) @(negedge clk);
    port_en = 1'b1;
    if (disturb) begin
      @(negedge clk);
      cfg_std = ~std; cfg_dsize = 2'b00; cfg_slot32 = 1'b0; cfg_tdm = 1'b1;
      cfg_slots = 5'd16;
    end
    d = (dsz == 2'b00) ? 16 : (dsz == 2'b01) ? 24 : 32;
    l = (dsz == 2'b00 && !s32) ? 16 : 32;
    n = tdm ? int'(slots) : 2;
    dly = (std == 2'b00) || (std == 2'b11);
    lead = (std == 2'b10) ? l - d : 0;
    used = 0; exp_ud = 0; exp_rdy = 0;
    for (int k = 0; k < frames * n; k++) begin
      w = 32'h0;
      if (mask[k % n]) begin
        exp_rdy++;
        if (used < words) begin w = fw[used]; used++; end
        else exp_ud++;
      end
      for (int p = 0; p < l; p++)
        exp_s[k * l + p] = (p >= lead && p < lead + d) ? w[d - 1 - (p - lead)] : 1'b0;
    end
    total = frames * n * l;
    got_ud = 0; got_rdy = 0;
    for (int g = 0; g < total; g++) begin
      bit_step((g % (n * l)) == 0, r, s, u);
      got_rdy += int'(r);
      got_ud  += int'(u);
      e = dly ? ((g == 0) ? 1'b0 : exp_s[g - 1]) : exp_s[g];
      check(s == e, tag, $sformatf("bit %0d", g), s, e);
    end
    check(got_rdy == exp_rdy, "R7", "fetch count", got_rdy, exp_rdy);
    check(fptr == used, "R7", "words consumed", fptr, used);
    check(got_ud == exp_ud, "R8", "underflow pulses", got_ud, exp_ud);
    port_en = 1'b0;
    @(negedge clk);
    #1;
    check(sdata == 1'b0, "R1", "sdata cleared on disable", sdata, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_quiet();
    // I2S, 16-bit sample in 16-bit slots (R4, R2, R3)
    run_case("R4/R2", 2'b00, 2'b00, 1'b0, 1'b0, 5'd2, 16'h0003, 3, 6, 1'b0, 1);
    // left-aligned 24-bit forced into 32-bit slots, settings disturbed while running (R5, R9)
    run_case("R5/R9/R3", 2'b01, 2'b01, 1'b0, 1'b0, 5'd2, 16'h0003, 2, 4, 1'b1, 7);
    // right-aligned 16-bit in 32-bit slots (R6)
    run_case("R6/R2", 2'b10, 2'b00, 1'b1, 1'b0, 5'd2, 16'h0003, 2, 4, 1'b0, 13);
    // PCM, 8-slot TDM with sparse mask, 32-bit (R4, R7)
    run_case("R4/R7", 2'b11, 2'b10, 1'b0, 1'b1, 5'd8, 16'h00A5, 2, 8, 1'b0, 21);
    // left-aligned 16-bit, source runs dry (R8)
    run_case("R8/R5", 2'b01, 2'b00, 1'b0, 1'b0, 5'd2, 16'h0003, 2, 3, 1'b0, 33);
    // right-aligned 24-bit in 4-slot TDM, middle slots only (R6, R7)
    run_case("R6/R7", 2'b10, 2'b01, 1'b1, 1'b1, 5'd4, 16'h0006, 2, 4, 1'b0, 45);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule